// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel that copies 32-bit words from a source address range to a destination address range. It does so through a simple bus master port that handles one access at a time. Software sets it up through a small register port with the source, the destination and a byte count. Software then sets the enable and trigger bits in the control register. The engine reads a word into its one-word internal buffer and writes that word to the destination. It then moves the current pointers and lowers the remaining count until the count reaches zero. At that point the engine clears the trigger bit and raises a done flag. If a bus access returns an error, the engine aborts, raises an abort flag and refuses new work until a soft reset.

The engine can run free (memory to memory), or it can be paced by a peripheral request line (peripheral to memory, or memory to peripheral). When paced, each word waits for the request and is answered with a one-cycle acknowledge. Each of the two address pointers either steps by one word or stays fixed. This lets the channel drain or fill a peripheral data register.

The bus master holds `bm_req`, `bm_we`, `bm_addr` and `bm_wdata` steady until the slave answers, in the same cycle, with `bm_ready` (completed) or `bm_err` (error). Register offsets are byte addresses: control 0x00, source 0x04, destination 0x08, byte count 0x0C, current source 0x10, current destination 0x14, remaining count 0x18, interrupt enable 0x1C, status 0x20, buffer 0x24. Any other offset reads as zero.

Top module: `dmac_chan`

## Requirements
- R1: After reset every register reads as zero, `irq` is 0 and `bm_req` is 0.
- R2: While the enable bit (control bit 0) is 0, the engine makes no bus access, ignores `periph_req` and leaves a set trigger bit untouched. Clearing enable during a transfer drops `bm_req` in the next cycle.
- R3: When the engine is idle, a transfer starts with the enable bit and the trigger bit (control bit 8) both set. At the start, the current source, current destination and remaining count load from the programmed values. Address bits [1:0] are forced to zero, so every `bm_addr` is word aligned.
- R4: The mode field (control bits [3:2]) selects free running for 00 and 11. For 01 and 10, each word's read waits until `periph_req` is 1, and `periph_ack` pulses for exactly one cycle, in the cycle after that word's write is accepted.
- R5: For each pointer, the direction field (source: control bits [5:4]; destination: control bits [7:6]) selects a step of +4 after each completed word for 00 and 01, and a fixed address for 10 and 11.
- R6: Each word read from the source is written unchanged to the destination. The word last read stays readable at offset 0x24, and a pending access keeps its address until it is answered.
- R7: The remaining count (offset 0x18, 16-bit value zero-extended to 24 bits) drops by 4, saturating at 0, only when a write is accepted. A count of C moves ceil(C/4) words, and a count of 0 completes with no bus access.
- R8: On completion the trigger bit is cleared by hardware and the done flag (status bit 0) is set.
- R9: A bus error on a read or a write stops the transfer. It sets the abort flag (status bit 1), idles the bus and leaves the trigger bit set. Later triggers are ignored until a soft reset.
- R10: Writing 1 to control bit 1 resets the engine and the current pointers, clears the enable bit, and clears itself one cycle later. Mode, direction, trigger and the programmed registers keep their values.
- R11: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged.
- R12: `irq` is 1 exactly when a status flag is set and its enable bit at offset 0x1C (bit 0 done, bit 1 abort) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bm_req | output | 1 | Bus access request |
| bm_we | output | 1 | Bus access is a write |
| bm_addr | output | 32 | Bus address |
| bm_wdata | output | 32 | Bus write data |
| bm_rdata | input | 32 | Bus read data |
| bm_ready | input | 1 | Access completed |
| bm_err | input | 1 | Access ended with an error |
| periph_req | input | 1 | Peripheral request for one word |
| periph_ack | output | 1 | One-cycle acknowledge per paced word |
| irq | output | 1 | Interrupt |

## Verification
The main copy function is swept over every mode and every pair of source and destination directions, with counts of one whole word, several whole words and a count that is not a multiple of four. Both aligned and misaligned programmed addresses are used. These runs separate stepping from fixed pointers, and pacing from free running, and they test the rounding of the word count. A stalled bus is stepped one accepted access at a time, which shows that the count moves on the write and not on the read. Error responses on a read and on a write, a disable during a transfer and a soft reset tell abort, lockout and recovery apart from normal completion.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } eng_st_e;

    localparam logic [1:0] MODE_P2M = 2'b01;
    localparam logic [1:0] MODE_M2P = 2'b10;

    // register word indices (byte offset / 4)
    localparam int IDX_CTRL = 0;
    localparam int IDX_SRC  = 1;
    localparam int IDX_DST  = 2;
    localparam int IDX_CNT  = 3;
    localparam int IDX_CSRC = 4;
    localparam int IDX_CDST = 5;
    localparam int IDX_CCNT = 6;
    localparam int IDX_IE   = 7;
    localparam int IDX_STAT = 8;
    localparam int IDX_BUF  = 9;

endpackage

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CNT_W  = 16,
    parameter int CCNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              srst,
    input  logic              trig,
    input  logic [1:0]        mode,
    input  logic [1:0]        sdir,
    input  logic [1:0]        ddir,
    input  logic [AW-1:0]     prog_src,
    input  logic [AW-1:0]     prog_dst,
    input  logic [CNT_W-1:0]  prog_cnt,
    input  logic              preq,
    output logic              pack,
    output logic              bm_req,
    output logic              bm_we,
    output logic [AW-1:0]     bm_addr,
    output logic [DW-1:0]     bm_wdata,
    input  logic [DW-1:0]     bm_rdata,
    input  logic              bm_ready,
    input  logic              bm_err,
    output logic [AW-1:0]     cur_src,
    output logic [AW-1:0]     cur_dst,
    output logic [CCNT_W-1:0] cur_cnt,
    output logic [DW-1:0]     buf_o,
    output logic              done_o,
    output logic              abort_o
);
    localparam int STEP = DW / 8;
    localparam int ALN  = $clog2(STEP);

    typedef struct packed {
        eng_st_e           st;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [CCNT_W-1:0] rem;
        logic [DW-1:0]     data;
        logic              blocked;
        logic              ack;
    } eng_t;

    eng_t q, d;
    logic paced, last;

    assign paced = (mode == MODE_P2M) || (mode == MODE_M2P);
    assign last  = (q.rem <= CCNT_W'(STEP));

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        done_o   = 1'b0;
        abort_o  = 1'b0;
        bm_req   = 1'b0;
        bm_we    = 1'b0;
        bm_addr  = q.src;
        bm_wdata = q.data;
        if (srst) begin
            d = '0;
        end else if (!en) begin
            d.st = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (trig && !q.blocked) begin
                        d.src = {prog_src[AW-1:ALN], {ALN{1'b0}}};
                        d.dst = {prog_dst[AW-1:ALN], {ALN{1'b0}}};
                        d.rem = CCNT_W'(prog_cnt);
                        if (prog_cnt == '0) done_o = 1'b1;
                        else d.st = paced ? ST_WAIT : ST_RD;
                    end
                end
                ST_WAIT: begin
                    if (preq) d.st = ST_RD;
                end
                ST_RD: begin
                    bm_req = 1'b1;
                    if (bm_err) begin
                        d.st = ST_IDLE; d.blocked = 1'b1; abort_o = 1'b1;
                    end else if (bm_ready) begin
                        d.data = bm_rdata;
                        d.st   = ST_WR;
                    end
                end
                ST_WR: begin
                    bm_req  = 1'b1;
                    bm_we   = 1'b1;
                    bm_addr = q.dst;
                    if (bm_err) begin
                        d.st = ST_IDLE; d.blocked = 1'b1; abort_o = 1'b1;
                    end else if (bm_ready) begin
                        d.src = sdir[1] ? q.src : q.src + AW'(STEP);
                        d.dst = ddir[1] ? q.dst : q.dst + AW'(STEP);
                        d.rem = last ? '0 : q.rem - CCNT_W'(STEP);
                        d.ack = paced;
                        if (last) begin
                            done_o = 1'b1;
                            d.st   = ST_IDLE;
                        end else begin
                            d.st = paced ? ST_WAIT : ST_RD;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pack    = q.ack;
    assign cur_src = q.src;
    assign cur_dst = q.dst;
    assign cur_cnt = q.rem;
    assign buf_o   = q.data;

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CNT_W  = 16,
    parameter int CCNT_W = 24,
    parameter int RAW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [AW-1:0]     cur_src,
    input  logic [AW-1:0]     cur_dst,
    input  logic [CCNT_W-1:0] cur_cnt,
    input  logic [DW-1:0]     buf_i,
    input  logic              done_i,
    input  logic              abort_i,
    output logic              ctl_en,
    output logic              ctl_srst,
    output logic              ctl_trig,
    output logic [1:0]        ctl_mode,
    output logic [1:0]        ctl_sdir,
    output logic [1:0]        ctl_ddir,
    output logic [AW-1:0]     prog_src,
    output logic [AW-1:0]     prog_dst,
    output logic [CNT_W-1:0]  prog_cnt,
    output logic              irq
);
    localparam int IW = RAW - 2;

    typedef struct packed {
        logic             en;
        logic             srst;
        logic [1:0]       mode;
        logic [1:0]       sdir;
        logic [1:0]       ddir;
        logic             trig;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       ie;
        logic [1:0]       st;
    } regs_t;

    regs_t q, d;
    logic [IW-1:0] idx;

    assign idx = reg_addr[RAW-1:2];

    always_comb begin
        d = q;
        if (q.srst) begin
            d.srst = 1'b0;
            d.en   = 1'b0;
        end
        if (reg_we) begin
            case (idx)
                IW'(IDX_CTRL): begin
                    d.en   = reg_wdata[0];
                    d.srst = reg_wdata[1];
                    d.mode = reg_wdata[3:2];
                    d.sdir = reg_wdata[5:4];
                    d.ddir = reg_wdata[7:6];
                    d.trig = reg_wdata[8];
                end
                IW'(IDX_SRC):  d.src = reg_wdata[AW-1:0];
                IW'(IDX_DST):  d.dst = reg_wdata[AW-1:0];
                IW'(IDX_CNT):  d.cnt = reg_wdata[CNT_W-1:0];
                IW'(IDX_IE):   d.ie  = reg_wdata[1:0];
                IW'(IDX_STAT): d.st  = q.st & ~reg_wdata[1:0];
                default: ;
            endcase
        end
        if (done_i) d.trig = 1'b0;
        d.st = d.st | {abort_i, done_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (idx)
            IW'(IDX_CTRL): reg_rdata = REG_W'({q.trig, q.ddir, q.sdir, q.mode, q.srst, q.en});
            IW'(IDX_SRC):  reg_rdata = REG_W'(q.src);
            IW'(IDX_DST):  reg_rdata = REG_W'(q.dst);
            IW'(IDX_CNT):  reg_rdata = REG_W'(q.cnt);
            IW'(IDX_CSRC): reg_rdata = REG_W'(cur_src);
            IW'(IDX_CDST): reg_rdata = REG_W'(cur_dst);
            IW'(IDX_CCNT): reg_rdata = REG_W'(cur_cnt);
            IW'(IDX_IE):   reg_rdata = REG_W'(q.ie);
            IW'(IDX_STAT): reg_rdata = REG_W'(q.st);
            IW'(IDX_BUF):  reg_rdata = REG_W'(buf_i);
            default:       reg_rdata = '0;
        endcase
    end

    assign ctl_en   = q.en;
    assign ctl_srst = q.srst;
    assign ctl_trig = q.trig;
    assign ctl_mode = q.mode;
    assign ctl_sdir = q.sdir;
    assign ctl_ddir = q.ddir;
    assign prog_src = q.src;
    assign prog_dst = q.dst;
    assign prog_cnt = q.cnt;
    assign irq      = |(q.st & q.ie);

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CNT_W  = 16,
    parameter int CCNT_W = 24,
    parameter int RAW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             bm_req,
    output logic             bm_we,
    output logic [AW-1:0]    bm_addr,
    output logic [DW-1:0]    bm_wdata,
    input  logic [DW-1:0]    bm_rdata,
    input  logic             bm_ready,
    input  logic             bm_err,
    input  logic             periph_req,
    output logic             periph_ack,
    output logic             irq
);
    logic              ctl_en, ctl_srst, ctl_trig;
    logic [1:0]        ctl_mode, ctl_sdir, ctl_ddir;
    logic [AW-1:0]     prog_src, prog_dst, cur_src, cur_dst;
    logic [CNT_W-1:0]  prog_cnt;
    logic [CCNT_W-1:0] cur_cnt;
    logic [DW-1:0]     buf_w;
    logic              done_p, abort_p;

    dmac_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .CCNT_W(CCNT_W), .RAW(RAW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt), .buf_i(buf_w),
        .done_i(done_p), .abort_i(abort_p),
        .ctl_en(ctl_en), .ctl_srst(ctl_srst), .ctl_trig(ctl_trig),
        .ctl_mode(ctl_mode), .ctl_sdir(ctl_sdir), .ctl_ddir(ctl_ddir),
        .prog_src(prog_src), .prog_dst(prog_dst), .prog_cnt(prog_cnt), .irq(irq)
    );

    dmac_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .CCNT_W(CCNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .srst(ctl_srst), .trig(ctl_trig),
        .mode(ctl_mode), .sdir(ctl_sdir), .ddir(ctl_ddir),
        .prog_src(prog_src), .prog_dst(prog_dst), .prog_cnt(prog_cnt),
        .preq(periph_req), .pack(periph_ack),
        .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
        .bm_rdata(bm_rdata), .bm_ready(bm_ready), .bm_err(bm_err),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt), .buf_o(buf_w),
        .done_o(done_p), .abort_o(abort_p)
    );

endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          ctl_en,
    input logic          ctl_srst,
    input logic          ctl_trig,
    input logic          done_p,
    input logic          abort_p,
    input logic          bm_req,
    input logic [AW-1:0] bm_addr,
    input logic          bm_ready,
    input logic          bm_err,
    input logic          periph_ack
);
    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !bm_req);

    // R3
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req |-> (bm_addr[1:0] == 2'b00));

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && !bm_ready && !bm_err) |=> (!ctl_en || ctl_srst || (bm_req && $stable(bm_addr))));

    // R8
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> !ctl_trig);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |=> !bm_req);

    // R10
    srst_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_srst && !reg_we) |=> (!ctl_srst && !ctl_en));

endmodule

bind dmac_chan dmac_chan_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .ctl_en(ctl_en), .ctl_srst(ctl_srst),
    .ctl_trig(ctl_trig), .done_p(done_p), .abort_p(abort_p), .bm_req(bm_req),
    .bm_addr(bm_addr), .bm_ready(bm_ready), .bm_err(bm_err), .periph_ack(periph_ack)
);

// File: tb/dmac_chan_tb_top.sv
`timescale 1ns/1ps
module dmac_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bm_req, bm_we, bm_ready, bm_err;
    logic [31:0] bm_addr, bm_wdata, bm_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack, irq;

    logic        hold = 1'b0;
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;

    int n_chk = 0;
    int n_fail = 0;
    int wr_total = 0;
    int ack_total = 0;
    int req_total = 0;
    logic [31:0] log_a [256];
    logic [31:0] log_d [256];

    always #10 clk = ~clk;

    dmac_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
        .bm_rdata(bm_rdata), .bm_ready(bm_ready), .bm_err(bm_err),
        .periph_req(periph_req), .periph_ack(periph_ack), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] cv(input logic en, input logic sr, input logic [1:0] m,
                                       input logic [1:0] sd, input logic [1:0] dd, input logic tr);
        return {23'b0, tr, dd, sd, m, sr, en};
    endfunction

    assign bm_err   = bm_req && err_on && (bm_addr == err_addr);
    assign bm_ready = bm_req && !hold && !bm_err;
    assign bm_rdata = pat(bm_addr);

    always @(posedge clk) begin
        if (bm_req && bm_we && bm_ready) begin
            log_a[wr_total[7:0]] <= bm_addr;
            log_d[wr_total[7:0]] <= bm_wdata;
            wr_total <= wr_total + 1;
        end
        if (periph_ack) ack_total <= ack_total + 1;
        if (bm_req) req_total <= req_total + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(6'h00, v);
            if (!v[8]) break;
        end
    endtask

    task automatic run(input logic [1:0] m, input logic [1:0] sd, input logic [1:0] dd,
                       input int cnt, input logic [31:0] src, input logic [31:0] dst,
                       input logic [1:0] ie);
        logic [31:0] v, s0, d0;
        int base, abase, words;
        s0 = {src[31:2], 2'b00};
        d0 = {dst[31:2], 2'b00};
        words = (cnt + 3) / 4;
        wr(6'h04, src); wr(6'h08, dst); wr(6'h0C, 32'(cnt)); wr(6'h1C, 32'(ie));
        base = wr_total; abase = ack_total;
        wr(6'h00, cv(1'b1, 1'b0, m, sd, dd, 1'b1));
        wait_done();
        repeat (2) @(negedge clk);
        check("R7 word count", 32'(wr_total - base), 32'(words));
        for (int k = 0; k < words && k < 8; k++) begin
            check("R5 dst addr", log_a[8'(base + k)], d0 + (dd[1] ? 32'd0 : 32'(4 * k)));
            check("R6 data", log_d[8'(base + k)], pat(s0 + (sd[1] ? 32'd0 : 32'(4 * k))));
        end
        rd(6'h10, v); check("R3/R5 cur src", v, s0 + (sd[1] ? 32'd0 : 32'(4 * words)));
        rd(6'h14, v); check("R3/R5 cur dst", v, d0 + (dd[1] ? 32'd0 : 32'(4 * words)));
        rd(6'h18, v); check("R7 remaining", v, 32'd0);
        rd(6'h00, v); check("R8 trigger cleared", 32'(v[8]), 32'd0);
        rd(6'h20, v); check("R8 done flag", v, 32'd1);
        check("R12 irq", 32'(irq), 32'(ie[0]));
        check("R4 ack count", 32'(ack_total - abase),
              (m == 2'b01 || m == 2'b10) ? 32'(words) : 32'd0);
        wr(6'h20, 32'h3);
        rd(6'h20, v); check("R11 w1c", v, 32'd0);
        check("R12 irq after clear", 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(6'(4 * a), v); check("R1 reset reg", v, 32'd0);
        end
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 bm_req", 32'(bm_req), 32'd0);

        // R2 trigger while disabled is ignored
        wr(6'h04, 32'h100); wr(6'h08, 32'h200); wr(6'h0C, 32'd8);
        rq = req_total;
        wr(6'h00, cv(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1));
        repeat (10) @(negedge clk);
        check("R2 no access while disabled", 32'(req_total - rq), 32'd0);
        rd(6'h00, v); check("R2 trigger kept", 32'(v[8]), 32'd1);
        wr(6'h00, cv(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0));

        // R4..R8 sweep
        periph_req = 1'b1;
        for (int m = 0; m < 4; m++)
            for (int sd = 0; sd < 4; sd++)
                for (int dd = 0; dd < 4; dd++)
                    for (int ci = 0; ci < 3; ci++)
                        run(2'(m), 2'(sd), 2'(dd), (ci == 0) ? 4 : (ci == 1) ? 14 : 8,
                            32'h2000 + 32'(m * 256) + ((ci == 1) ? 32'd3 : 32'd0),
                            32'h8000 + 32'(sd * 256) + ((ci == 2) ? 32'd2 : 32'd0),
                            2'(ci & 1));

        // R7 zero count
        base = wr_total; rq = req_total;
        run(2'b00, 2'b00, 2'b00, 0, 32'h700, 32'h900, 2'b01);
        check("R7 zero count no access", 32'(req_total - rq), 32'd0);

        // R4 pacing: request low holds the engine
        periph_req = 1'b0;
        wr(6'h04, 32'hA00); wr(6'h08, 32'hB00); wr(6'h0C, 32'd8);
        rq = req_total; base = ack_total;
        wr(6'h00, cv(1'b1, 1'b0, 2'b01, 2'b00, 2'b10, 1'b1));
        repeat (20) @(negedge clk);
        check("R4 wait for request", 32'(req_total - rq), 32'd0);
        periph_req = 1'b1;
        wait_done();
        repeat (2) @(negedge clk);
        check("R4 acks after request", 32'(ack_total - base), 32'd2);
        wr(6'h20, 32'h3);

        // R7/R6 count moves on write, not read
        hold = 1'b1;
        wr(6'h04, 32'h3000); wr(6'h08, 32'h4000); wr(6'h0C, 32'd8);
        wr(6'h00, cv(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1));
        repeat (2) @(negedge clk);
        check("R6 read pending", 32'({bm_req, bm_we}), 32'b10);
        check("R6 read addr", bm_addr, 32'h3000);
        rd(6'h18, v); check("R7 count before read", v, 32'd8);
        hold = 1'b0; @(negedge clk); hold = 1'b1;
        check("R6 write pending", 32'({bm_req, bm_we}), 32'b11);
        rd(6'h18, v); check("R7 count unchanged by read", v, 32'd8);
        hold = 1'b0; @(negedge clk); hold = 1'b1;
        rd(6'h18, v); check("R7 count after write", v, 32'd4);
        rd(6'h24, v); check("R6 buffer readback", v, pat(32'h3000));
        rd(6'h10, v); check("R5 src stepped", v, 32'h3004);
        hold = 1'b0;
        wait_done();
        wr(6'h20, 32'h3);

        // R2 disable mid-transfer, R10 soft reset
        hold = 1'b1;
        wr(6'h00, cv(1'b1, 1'b0, 2'b10, 2'b10, 2'b01, 1'b1));
        repeat (3) @(negedge clk);
        check("R2 busy before disable", 32'(bm_req), 32'd1);
        wr(6'h00, cv(1'b0, 1'b0, 2'b10, 2'b10, 2'b01, 1'b1));
        check("R2 bus idle after disable", 32'(bm_req), 32'd0);
        wr(6'h00, cv(1'b1, 1'b1, 2'b10, 2'b10, 2'b01, 1'b1));
        @(negedge clk);
        rd(6'h00, v); check("R10 ctrl kept, en/srst cleared", v, cv(1'b0, 1'b0, 2'b10, 2'b10, 2'b01, 1'b1));
        rd(6'h18, v); check("R10 count cleared", v, 32'd0);
        rd(6'h10, v); check("R10 src cleared", v, 32'd0);
        rd(6'h0C, v); check("R10 programmed count kept", v, 32'd8);
        hold = 1'b0;
        wr(6'h00, cv(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0));

        // R9 read error
        wr(6'h04, 32'h5000); wr(6'h08, 32'h6000); wr(6'h0C, 32'd12); wr(6'h1C, 32'h3);
        err_on = 1'b1; err_addr = 32'h5004;
        base = wr_total;
        wr(6'h00, cv(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1));
        repeat (15) @(negedge clk);
        rd(6'h20, v); check("R9 abort flag", v, 32'd2);
        rd(6'h00, v); check("R9 trigger kept", 32'(v[8]), 32'd1);
        check("R9 writes before abort", 32'(wr_total - base), 32'd1);
        check("R9 bus idle", 32'(bm_req), 32'd0);
        check("R12 abort irq", 32'(irq), 32'd1);
        err_on = 1'b0;
        rq = req_total;
        wr(6'h00, cv(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1));
        repeat (10) @(negedge clk);
        check("R9 locked out", 32'(req_total - rq), 32'd0);
        wr(6'h20, 32'h2);
        rd(6'h20, v); check("R11 abort cleared", v, 32'd0);
        check("R12 irq low", 32'(irq), 32'd0);
        wr(6'h00, cv(1'b0, 1'b1, 2'b00, 2'b00, 2'b00, 1'b0));
        base = wr_total;
        wr(6'h00, cv(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1));
        wait_done();
        repeat (2) @(negedge clk);
        check("R10 recovery transfer", 32'(wr_total - base), 32'd3);
        rd(6'h20, v); check("R8 done after recovery", v, 32'd1);
        wr(6'h20, 32'h1);
        rd(6'h20, v); check("R11 w0 keeps nothing set", v, 32'd0);

        // R9 write error, R7 count unchanged on failed write
        wr(6'h0C, 32'd4);
        err_on = 1'b1; err_addr = 32'h6000;
        base = wr_total;
        wr(6'h00, cv(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1));
        repeat (10) @(negedge clk);
        rd(6'h20, v); check("R9 write abort flag", v, 32'd2);
        check("R9 no write accepted", 32'(wr_total - base), 32'd0);
        rd(6'h18, v); check("R7 count kept on error", v, 32'd4);
        err_on = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule